// File: doc/BRIEF.md
# BCD Calendar Clock Register Bank

This block is an eight-byte calendar clock that occupies the highest eight byte addresses of a byte-wide memory space. It counts seconds, minutes, hours, day of week, date, month and year in packed BCD. Each one-cycle pulse on the `tick` input advances the count by one second.

A host reaches the bytes through a synchronous bus sampled on `clk`. The bus has active-low chip-enable, write-enable and output-enable, an address and a byte of write data. A control byte holds two latch bits:
- The read latch freezes a copy of the time so that several bytes can be read as one consistent set.
- The write latch halts counting, collects new values from the host, and loads them all at once when it is cleared.

Bits of a clock byte that belong to no counter field are plain storage. A power-fail input shuts out all host access and pulls an active-low status output low. Counting continues while the power-fail input is asserted.

Top module: `bcdclk_bank`

## Requirements
- R1: The eight highest addresses (upper address bits all ones) are decoded by address bits [2:0]: 0 control, 1 seconds, 2 minutes, 3 hours, 4 day of week, 5 date, 6 month, 7 year. Reset clears all eight bytes to 00, and each byte reads back the value written to it.
- R2: On a counted tick, seconds advance in BCD and go from 59 to 00 with a carry into minutes. Minutes go from 59 to 00 with a carry into hours. Seconds occupy bits [6:0] and minutes occupy bits [6:0].
- R3: Hours (bits [5:0]) go from 23 to 00, and that carry advances both day of week and date. Day of week (bits [2:0]) goes from 07 to 01.
- R4: Date (bits [5:0]) goes to 01 after the last day of the current month, with a carry into month. April, June, September and November have 30 days. February has 29 days when the BCD year is divisible by 4 and 28 days otherwise. All other months have 31 days. Month (bits [4:0]) goes from 12 to 01 with a carry into year, and year goes from 99 to 00.
- R5: While seconds bit 7 (the stop bit) is 1, ticks are ignored and every byte holds its value.
- R6: Bits outside the counter fields are stored and read back unchanged, and counting never alters them. This covers control bits [5:0], seconds bit 7, minutes bit 7, hours bits [7:6], day bits [7:3], date bits [7:6] and month bits [7:5].
- R7: Writing control bit 6 (read latch) from 0 to 1 captures the time. While bit 6 is 1, reads of bytes 1 to 7 return that capture while the live counters keep advancing, and the advanced values are visible once bit 6 is cleared.
- R8: While control bit 7 (write latch) is 1, counting halts and host writes to bytes 1 to 7 fill a staging copy that reads back. Clearing bit 7 loads the whole staging copy into the counters in that same cycle.
- R9: A write changes only the addressed byte. An out-of-range BCD value is stored as written, and the next tick that reaches the field wraps it to its low value and carries onward.
- R10: While `pwr_fail` is 1, `pfo_n` is 0, reads do not drive, writes are ignored, and ticks are still counted. `pfo_n` is 1 whenever `pwr_fail` is 0.
- R11: `rd_oe` is 1 only when chip-enable and output-enable are active, write-enable is inactive and the address is in the window. Otherwise `rdata` is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse, one per second |
| addr | input | ADDR_W | Byte address |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, 00 when not driving |
| rd_oe | output | 1 | Read data driver enable |
| pwr_fail | input | 1 | Supply failing, blocks host access |
| pfo_n | output | 1 | Power-fail status, active low |

## Verification
The hardest case to reach is the date rollover across every month length. This includes a leap February and the year wrap, which from the ports would normally need millions of ticks. Before each tick, the stimulus writes 23:59:59 into the hour, minute and second bytes, so that each tick advances exactly one day. The bench runs three calendar years starting in year 98 and compares date, month, year and day of week with an arithmetic calendar after every day. The second and minute counters are swept tick by tick over a full hour in the same way.

// File: rtl/bcdclk_pkg.sv
package bcdclk_pkg;

   localparam int NREG    = 8;
   localparam int IX_CTRL = 0;
   localparam int IX_SEC  = 1;
   localparam int IX_MIN  = 2;
   localparam int IX_HOUR = 3;
   localparam int IX_WDAY = 4;
   localparam int IX_MDAY = 5;
   localparam int IX_MON  = 6;
   localparam int IX_YEAR = 7;

   localparam int CTRL_WLATCH = 7;
   localparam int CTRL_RLATCH = 6;
   localparam int SEC_STOP    = 7;

   // bits of each byte owned by a counter field
   function automatic logic [7:0] fld_mask(input int ix);
      case (ix)
         IX_SEC, IX_MIN:   return 8'h7F;
         IX_HOUR, IX_MDAY: return 8'h3F;
         IX_WDAY:          return 8'h07;
         IX_MON:           return 8'h1F;
         IX_YEAR:          return 8'hFF;
         default:          return 8'h00;
      endcase
   endfunction

   function automatic logic [7:0] fld_floor(input int ix);
      case (ix)
         IX_WDAY, IX_MDAY, IX_MON: return 8'h01;
         default:                  return 8'h00;
      endcase
   endfunction

   function automatic logic [7:0] fld_ceil(input int ix);
      case (ix)
         IX_SEC, IX_MIN: return 8'h59;
         IX_HOUR:        return 8'h23;
         IX_WDAY:        return 8'h07;
         IX_MDAY:        return 8'h31;
         IX_MON:         return 8'h12;
         default:        return 8'h99;
      endcase
   endfunction

   // which field's wrap advances this field; 0 means the tick itself
   function automatic int fld_parent(input int ix);
      case (ix)
         IX_MIN:           return IX_SEC;
         IX_HOUR:          return IX_MIN;
         IX_WDAY, IX_MDAY: return IX_HOUR;
         IX_MON:           return IX_MDAY;
         IX_YEAR:          return IX_MON;
         default:          return 0;
      endcase
   endfunction

   function automatic logic [7:0] bcd_next(input logic [7:0] v);
      logic [7:0] r;
      if (v[3:0] >= 4'd9) begin
         r[3:0] = 4'd0;
         r[7:4] = v[7:4] + 4'd1;
      end else begin
         r[3:0] = v[3:0] + 4'd1;
         r[7:4] = v[7:4];
      end
      return r;
   endfunction

   function automatic logic [7:0] month_len(input logic [7:0] mon,
                                            input logic [7:0] yr,
                                            input bit leap_en);
      int yb;
      yb = int'(yr[7:4]) * 10 + int'(yr[3:0]);
      case (mon[4:0])
         5'h02:                      return (leap_en && (yb % 4 == 0)) ? 8'h29 : 8'h28;
         5'h04, 5'h06, 5'h09, 5'h11: return 8'h30;
         default:                    return 8'h31;
      endcase
   endfunction

endpackage

// File: rtl/bcdclk_step.sv
module bcdclk_step #(
   parameter logic [7:0] MASK  = 8'h7F,
   parameter logic [7:0] FLOOR = 8'h00
) (
   input  logic [7:0] cur,
   input  logic [7:0] ceil,
   input  logic       en,
   output logic [7:0] nxt,
   output logic       wrap
);
   logic [7:0] val;
   logic [7:0] inc;
   logic       at_top;

   always_comb begin
      val    = cur & MASK;
      inc    = bcdclk_pkg::bcd_next(val);
      at_top = (val >= ceil);
      wrap   = en && at_top;
      if (!en)
         nxt = cur;
      else if (at_top)
         nxt = (cur & ~MASK) | (FLOOR & MASK);
      else
         nxt = (cur & ~MASK) | (inc & MASK);
   end
endmodule

// File: rtl/bcdclk_chain.sv
module bcdclk_chain #(
   parameter bit LEAP_EN = 1'b1
) (
   input  logic       tick_ok,
   input  logic [7:0] cur [1:7],
   output logic [7:0] nxt [1:7]
);
   import bcdclk_pkg::*;

   logic en_w    [1:7];
   logic carry_w [1:7];

   for (genvar i = 1; i < NREG; i++) begin : g_fld
      localparam int P = fld_parent(i);
      logic [7:0] ceil_w;

      if (i == IX_MDAY) begin : g_dyn
         assign ceil_w = month_len(cur[IX_MON], cur[IX_YEAR], LEAP_EN);
      end else begin : g_fix
         assign ceil_w = fld_ceil(i);
      end

      if (P == 0) begin : g_root
         assign en_w[i] = tick_ok;
      end else begin : g_link
         assign en_w[i] = carry_w[P];
      end

      bcdclk_step #(
         .MASK  (fld_mask(i)),
         .FLOOR (fld_floor(i))
      ) u_step (
         .cur  (cur[i]),
         .ceil (ceil_w),
         .en   (en_w[i]),
         .nxt  (nxt[i]),
         .wrap (carry_w[i])
      );
   end
endmodule

// File: rtl/bcdclk_host.sv
module bcdclk_host #(
   parameter int ADDR_W = 17
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              ce_n,
   input  logic              we_n,
   input  logic              oe_n,
   input  logic              pwr_fail,
   output logic [2:0]        idx,
   output logic              wr_stb,
   output logic              rd_drv
);
   localparam int HI_W = ADDR_W - 3;

   logic ce_act;
   logic hit;

   assign ce_act = !ce_n && !pwr_fail;
   assign hit    = (addr[ADDR_W-1:3] == {HI_W{1'b1}});
   assign idx    = addr[2:0];
   assign wr_stb = ce_act && !we_n && hit;
   assign rd_drv = ce_act && we_n && !oe_n && hit;
endmodule

// File: rtl/bcdclk_bank.sv
module bcdclk_bank #(
   parameter int ADDR_W  = 17,
   parameter bit LEAP_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic [ADDR_W-1:0] addr,
   input  logic              ce_n,
   input  logic              we_n,
   input  logic              oe_n,
   input  logic [7:0]        wdata,
   output logic [7:0]        rdata,
   output logic              rd_oe,
   input  logic              pwr_fail,
   output logic              pfo_n
);
   import bcdclk_pkg::*;

   initial begin : g_param_chk
      assert (ADDR_W >= 4) else $error("ADDR_W must be at least 4");
   end

   logic [2:0] idx;
   logic       wr_stb;
   logic       rd_drv;

   logic [7:0] live_q [NREG];
   logic [7:0] shad_q [NREG];
   logic [7:0] clk_cur [1:7];
   logic [7:0] cnt_nxt [1:7];

   logic w_latch, r_latch, stop;
   logic tick_ok, ctl_wr, w_set, w_clear, r_set;
   logic [7:0] rsel;

   bcdclk_host #(.ADDR_W(ADDR_W)) u_host (
      .addr     (addr),
      .ce_n     (ce_n),
      .we_n     (we_n),
      .oe_n     (oe_n),
      .pwr_fail (pwr_fail),
      .idx      (idx),
      .wr_stb   (wr_stb),
      .rd_drv   (rd_drv)
   );

   always_comb begin
      for (int i = 1; i < NREG; i++) clk_cur[i] = live_q[i];
   end

   bcdclk_chain #(.LEAP_EN(LEAP_EN)) u_chain (
      .tick_ok (tick_ok),
      .cur     (clk_cur),
      .nxt     (cnt_nxt)
   );

   assign w_latch = live_q[IX_CTRL][CTRL_WLATCH];
   assign r_latch = live_q[IX_CTRL][CTRL_RLATCH];
   assign stop    = live_q[IX_SEC][SEC_STOP];
   assign tick_ok = tick && !w_latch && !stop;
   assign ctl_wr  = wr_stb && (idx == 3'(IX_CTRL));
   assign w_set   = ctl_wr && !w_latch && wdata[CTRL_WLATCH];
   assign w_clear = ctl_wr && w_latch && !wdata[CTRL_WLATCH];
   assign r_set   = ctl_wr && !r_latch && wdata[CTRL_RLATCH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NREG; i++) begin
            live_q[i] <= 8'h00;
            shad_q[i] <= 8'h00;
         end
      end else begin
         if (ctl_wr) live_q[IX_CTRL] <= wdata;
         for (int i = 1; i < NREG; i++) begin
            if (w_clear)
               live_q[i] <= shad_q[i];
            else if (wr_stb && (idx == 3'(i)) && !w_latch)
               live_q[i] <= wdata;
            else
               live_q[i] <= cnt_nxt[i];

            if (w_set || r_set)
               shad_q[i] <= live_q[i];
            else if (wr_stb && (idx == 3'(i)))
               shad_q[i] <= wdata;
         end
      end
   end

   always_comb begin
      if (idx == 3'(IX_CTRL))
         rsel = live_q[IX_CTRL];
      else if (w_latch || r_latch)
         rsel = shad_q[idx];
      else
         rsel = live_q[idx];
   end

   assign rdata = rd_drv ? rsel : 8'h00;
   assign rd_oe = rd_drv;
   assign pfo_n = !pwr_fail;

endmodule

// File: rtl/bcdclk_bank_chk.sv
module bcdclk_bank_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        ce_n,
   input logic        we_n,
   input logic        oe_n,
   input logic        pwr_fail,
   input logic        pfo_n,
   input logic        rd_oe,
   input logic        wr_stb,
   input logic        tick_ok,
   input logic [63:0] live_flat
);
   // bits not owned by a counter, byte 7 down to byte 0
   localparam logic [63:0] SPARE = 64'h00E0_C0F8_C080_80FF;

   assert_lockout_R10: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_fail |-> (!rd_oe && !pfo_n && !wr_stb));

   assert_pfo_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_fail |-> pfo_n);

   assert_drive_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
      rd_oe |-> (!ce_n && we_n && !oe_n));

   assert_stop_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_stb && live_flat[15]) |=> $stable(live_flat));

   assert_wlatch_halt_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_stb && live_flat[7]) |=> $stable(live_flat));

   assert_spare_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_stb |=> $stable(live_flat & SPARE));

   assert_sec_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_ok && !wr_stb && live_flat[14:8] == 7'h59) |=> (live_flat[14:8] == 7'h00));
endmodule

bind bcdclk_bank bcdclk_bank_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ce_n      (ce_n),
   .we_n      (we_n),
   .oe_n      (oe_n),
   .pwr_fail  (pwr_fail),
   .pfo_n     (pfo_n),
   .rd_oe     (rd_oe),
   .wr_stb    (wr_stb),
   .tick_ok   (tick_ok),
   .live_flat ({live_q[7], live_q[6], live_q[5], live_q[4],
                live_q[3], live_q[2], live_q[1], live_q[0]})
);

// File: tb/bcdclk_bank_tb.sv
module bcdclk_bank_tb;
   localparam int AW = 17;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tick = 1'b0;
   logic [AW-1:0] addr = '0;
   logic          ce_n = 1'b1;
   logic          we_n = 1'b1;
   logic          oe_n = 1'b1;
   logic [7:0]    wdata = 8'h00;
   logic          pwr_fail = 1'b0;
   logic [7:0]    rdata;
   logic          rd_oe;
   logic          pfo_n;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   bcdclk_bank #(.ADDR_W(AW)) u_dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .addr(addr), .ce_n(ce_n),
      .we_n(we_n), .oe_n(oe_n), .wdata(wdata), .rdata(rdata),
      .rd_oe(rd_oe), .pwr_fail(pwr_fail), .pfo_n(pfo_n)
   );

   function automatic logic [AW-1:0] a_of(input int ix);
      return {{(AW-3){1'b1}}, 3'(ix)};
   endfunction

   function automatic logic [7:0] bcd(input int v);
      return 8'(((v / 10) << 4) | (v % 10));
   endfunction

   function automatic int mlen(input int m, input int y);
      if (m == 2) return (y % 4 == 0) ? 29 : 28;
      if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
      return 31;
   endfunction

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input int ix, input logic [7:0] v);
      @(negedge clk);
      addr = a_of(ix); wdata = v; ce_n = 1'b0; we_n = 1'b0;
      @(negedge clk);
      ce_n = 1'b1; we_n = 1'b1;
   endtask

   task automatic bus_rd(input logic [AW-1:0] a, input logic oe_in,
                         output logic [7:0] v, output logic drv);
      @(negedge clk);
      addr = a; ce_n = 1'b0; we_n = 1'b1; oe_n = oe_in;
      #1;
      v = rdata; drv = rd_oe;
      ce_n = 1'b1; oe_n = 1'b1;
   endtask

   task automatic rd(input int ix, output logic [7:0] v);
      logic d;
      bus_rd(a_of(ix), 1'b0, v, d);
   endtask

   task automatic tk(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk); tick = 1'b1;
         @(negedge clk); tick = 1'b0;
      end
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      logic [7:0] v;
      logic       d;
      int s, mi, y, m, dt, wd;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      for (int i = 0; i < 8; i++) begin
         rd(i, v); chk("R1 reset", v, 8'h00);
      end

      // R1 map and readback
      wr(1, 8'h11); wr(2, 8'h22); wr(3, 8'h13); wr(4, 8'h04);
      wr(5, 8'h25); wr(6, 8'h06); wr(7, 8'h47);
      rd(1, v); chk("R1 sec", v, 8'h11);
      rd(2, v); chk("R1 min", v, 8'h22);
      rd(3, v); chk("R1 hour", v, 8'h13);
      rd(4, v); chk("R1 wday", v, 8'h04);
      rd(5, v); chk("R1 date", v, 8'h25);
      rd(6, v); chk("R1 month", v, 8'h06);
      rd(7, v); chk("R1 year", v, 8'h47);

      // R2 full hour sweep of seconds and minutes
      wr(3, 8'h05); wr(2, 8'h00); wr(1, 8'h00);
      s = 0; mi = 0;
      for (int t = 0; t < 3600; t++) begin
         tk(1);
         s++;
         if (s == 60) begin s = 0; mi++; end
         if (mi == 60) mi = 0;
         rd(1, v); chk("R2 sec", v, bcd(s));
         rd(2, v); chk("R2 min", v, bcd(mi));
      end
      rd(3, v); chk("R2 hour carry", v, 8'h06);

      // R3 hour wrap into day and date
      wr(4, 8'h07); wr(5, 8'h10); wr(6, 8'h03);
      wr(3, 8'h23); wr(2, 8'h59); wr(1, 8'h59);
      tk(1);
      rd(3, v); chk("R3 hour", v, 8'h00);
      rd(4, v); chk("R3 wday 7->1", v, 8'h01);
      rd(5, v); chk("R3 date", v, 8'h11);

      // R4 three calendar years, one tick per day
      y = 98; m = 1; dt = 1; wd = 1;
      wr(7, bcd(y)); wr(6, bcd(m)); wr(5, bcd(dt)); wr(4, bcd(wd));
      for (int n = 0; n < 1100; n++) begin
         wr(3, 8'h23); wr(2, 8'h59); wr(1, 8'h59);
         tk(1);
         wd = (wd == 7) ? 1 : wd + 1;
         dt++;
         if (dt > mlen(m, y)) begin
            dt = 1; m++;
            if (m > 12) begin m = 1; y = (y + 1) % 100; end
         end
         rd(5, v); chk("R4 date", v, bcd(dt));
         rd(6, v); chk("R4 month", v, bcd(m));
         rd(7, v); chk("R4 year", v, bcd(y));
         rd(4, v); chk("R3 wday", v, bcd(wd));
      end

      // R5 stop bit
      wr(1, 8'h92); tk(6);
      rd(1, v); chk("R5 stopped", v, 8'h92);
      wr(1, 8'h12); tk(1);
      rd(1, v); chk("R5 restarted", v, 8'h13);

      // R6 spare bits survive carries
      wr(4, 8'hF7); wr(3, 8'hE3); wr(2, 8'hD9); wr(1, 8'hD9);
      rd(1, v); chk("R6 sec stop bit set", v, 8'hD9);
      wr(1, 8'h59);
      tk(1);
      rd(1, v); chk("R6 sec", v, 8'h00);
      rd(2, v); chk("R6 min spare", v, 8'h80);
      rd(3, v); chk("R6 hour spare", v, 8'hC0);
      rd(4, v); chk("R6 wday spare", v, 8'hF1);
      wr(0, 8'h2A); rd(0, v); chk("R6 ctrl spare", v, 8'h2A);
      wr(1, 8'h05); tk(1);
      rd(1, v); chk("R6 ctrl spare no effect", v, 8'h06);
      wr(0, 8'h00);

      // R7 read latch
      wr(1, 8'h10); wr(0, 8'h40); tk(5);
      rd(1, v); chk("R7 snapshot", v, 8'h10);
      rd(0, v); chk("R7 ctrl", v, 8'h40);
      wr(0, 8'h00);
      rd(1, v); chk("R7 live advanced", v, 8'h15);

      // R8 write latch
      wr(1, 8'h20); wr(2, 8'h33); wr(0, 8'h80); tk(4);
      rd(1, v); chk("R8 halted", v, 8'h20);
      wr(1, 8'h45);
      rd(1, v); chk("R8 staging readback", v, 8'h45);
      tk(2);
      wr(0, 8'h00);
      rd(1, v); chk("R8 loaded", v, 8'h45);
      rd(2, v); chk("R8 min held", v, 8'h33);
      tk(1);
      rd(1, v); chk("R8 resumes", v, 8'h46);

      // R9 out-of-range settle and single-byte write
      wr(1, 8'h5A); wr(2, 8'h10);
      rd(1, v); chk("R9 stored raw", v, 8'h5A);
      tk(1);
      rd(1, v); chk("R9 settled", v, 8'h00);
      rd(2, v); chk("R9 carry", v, 8'h11);
      wr(2, 8'h22);
      rd(1, v); chk("R9 neighbour", v, 8'h00);

      // R10 power fail
      @(negedge clk); pwr_fail = 1'b1;
      #1; chk("R10 pfo low", {7'd0, pfo_n}, 8'h00);
      bus_rd(a_of(1), 1'b0, v, d);
      chk("R10 no drive", {7'd0, d}, 8'h00);
      chk("R10 rdata", v, 8'h00);
      wr(1, 8'h40);
      tk(3);
      @(negedge clk); pwr_fail = 1'b0;
      #1; chk("R10 pfo high", {7'd0, pfo_n}, 8'h01);
      rd(1, v); chk("R10 counted, write blocked", v, 8'h03);

      // R11 drive gating
      bus_rd(a_of(1), 1'b1, v, d);
      chk("R11 oe inactive", {7'd0, d}, 8'h00);
      chk("R11 rdata idle", v, 8'h00);
      bus_rd({1'b0, a_of(1)[AW-2:0]}, 1'b0, v, d);
      chk("R11 outside window", {7'd0, d}, 8'h00);
      bus_rd(a_of(1), 1'b0, v, d);
      chk("R11 drive on", {7'd0, d}, 8'h01);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule